// File: doc/BRIEF.md
# Thread-Aware Operand Bypass and Hazard Interlock

This block decides, every cycle, where the operands of a four-stage in-order load/store pipeline come from. The stages are fetch (IF), decode with register read and branch compare (ID), execute (EX), and memory with write-back (MEM). The block has no state. It compares the source registers of the instructions in ID and EX against the destinations of the instructions further down the pipe, and it compares their hardware-thread tags as well. From those matches it chooses the bypass selects for the datapath and raises a stall request.

There are three producer views. The MEM-stage instruction offers its result to EX on the ALU path. The instruction that retired in the previous cycle, whose write the register read missed, offers its result to EX on the MEM path. The MEM-stage result also feeds the ID branch comparator on the BRANCH path. Each path has its own enable parameter. In interleaved threading, the block also removes any path or interlock that spans a stage distance at which the round-robin schedule already guarantees a different thread.

A stall holds fetch and decode for one cycle and puts one bubble into EX. Parameters select a branch delay slot and a load delay slot. These are plain control pins; nothing here is a data stream, so no valid/ready handshake exists.

Top module: `hzfwd_unit`

## Requirements
- R1: An EX source equal to the MEM-stage destination gives select 1 (ALU path). A match needs write-enable high, a nonzero destination and equal thread tags.
- R2: An EX source that matches only the retired instruction, under the same match rule, gives select 2 (MEM path).
- R3: When both producers match one EX source, select 1 wins because the MEM-stage producer is the younger one.
- R4: Register 0 is never forwarded and never causes a stall.
- R5: Producers whose thread tag differs from the consumer's cause no forward and no stall.
- R6: Without a match, the select is 0 (register file). Code 3 never appears.
- R7: For a branch in ID, each used source that matches the MEM-stage destination raises its branch-forward bit.
- R8: A load in EX whose destination matches a used ID source raises stall. A non-load in EX raises no stall unless the ID instruction is a branch.
- R9: A branch in ID whose used source matches any EX-stage destination raises stall.
- R10: With no branch delay slot, a taken branch raises squash_slot. With a delay slot, squash_slot stays 0.
- R11: With a load delay slot configured, a load-use match never raises stall.
- R12: With interleaved threading and two threads, select 1 and stall never appear. The MEM and BRANCH paths stay, and they compare the 1-bit thread tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | REG_AW | EX first source register |
| ex_rt | input | REG_AW | EX second source register |
| ex_tid | input | TID_W | EX thread tag |
| id_rs | input | REG_AW | ID first source register |
| id_rt | input | REG_AW | ID second source register |
| id_use_rs | input | 1 | ID reads first source |
| id_use_rt | input | 1 | ID reads second source |
| id_tid | input | TID_W | ID thread tag |
| id_branch | input | 1 | ID holds a conditional branch |
| br_taken | input | 1 | Branch in ID resolved taken |
| x_we | input | 1 | EX instruction writes a register |
| x_rd | input | REG_AW | EX destination register |
| x_tid | input | TID_W | EX thread tag |
| x_load | input | 1 | EX instruction is a load |
| m_we | input | 1 | MEM instruction writes a register |
| m_rd | input | REG_AW | MEM destination register |
| m_tid | input | TID_W | MEM thread tag |
| w_we | input | 1 | Retired instruction wrote a register |
| w_rd | input | REG_AW | Retired destination register |
| w_tid | input | TID_W | Retired thread tag |
| ex_rs_sel | output | 2 | First EX operand source: 0 regfile, 1 ALU, 2 MEM |
| ex_rt_sel | output | 2 | Second EX operand source, same coding |
| br_rs_fwd | output | 1 | Branch first operand from MEM-stage result |
| br_rt_fwd | output | 1 | Branch second operand from MEM-stage result |
| stall | output | 1 | Hold IF and ID, bubble into EX |
| squash_slot | output | 1 | Kill the instruction fetched after a taken branch |

## Verification
Three things can happen in the same cycle: the EX bypass selection, a stall raised by the ID instruction, and the branch-forward decision. The bench builds vectors where an EX operand matches both producers while the EX-stage load also blocks an ID source. It then checks that the stall does not disturb the select and that the younger producer still wins. A second instance built for two interleaved threads with both delay slots receives the same vectors. Its outputs are judged against the pruned expectations, which the bench computes arithmetically from the requirement rules.

// File: rtl/hzfwd_pkg.sv
package hzfwd_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_ALU     = 2'd1,
    SRC_MEM     = 2'd2
  } opnd_src_e;
endpackage

// File: rtl/hzfwd_match.sv
module hzfwd_match #(
  parameter int RW = 5,
  parameter int TW = 2
) (
  input  logic [RW-1:0] src,
  input  logic          src_used,
  input  logic [TW-1:0] src_tid,
  input  logic          prod_we,
  input  logic [RW-1:0] prod_rd,
  input  logic [TW-1:0] prod_tid,
  output logic          hit
);
  assign hit = src_used && prod_we && (prod_rd != '0) &&
               (prod_rd == src) && (prod_tid == src_tid);

  always_comb begin
    AST_ZERO_REG_NOHIT: assert (!(hit && (src == '0))) else $error("r0 hit"); // R4
    AST_TAG_SAME: assert (!hit || (src_tid == prod_tid)) else $error("tag"); // R5
  end
endmodule

// File: rtl/hzfwd_opsel.sv
module hzfwd_opsel
  import hzfwd_pkg::*;
#(
  parameter bit EN_ALU = 1'b1,
  parameter bit EN_MEM = 1'b1
) (
  input  logic       near_hit,
  input  logic       far_hit,
  output logic [1:0] sel
);
  opnd_src_e choice;

  always_comb begin
    choice = SRC_REGFILE;
    if (EN_ALU && near_hit)      choice = SRC_ALU;
    else if (EN_MEM && far_hit)  choice = SRC_MEM;
  end

  assign sel = choice;

  always_comb begin
    AST_SEL_CODE: assert (sel != 2'd3) else $error("bad select"); // R6
    AST_YOUNG_FIRST: assert (!(EN_ALU && near_hit) || sel == 2'd1) else $error("prio"); // R3
  end
endmodule

// File: rtl/hzfwd_stall.sv
module hzfwd_stall #(
  parameter bit CHK_LOAD   = 1'b1,
  parameter bit CHK_BRANCH = 1'b1
) (
  input  logic x_load,
  input  logic id_branch,
  input  logic x_hit_rs,
  input  logic x_hit_rt,
  output logic stall
);
  logic any_hit;
  logic load_use;
  logic branch_use;

  assign any_hit = x_hit_rs || x_hit_rt;

  generate
    if (CHK_LOAD) begin : g_load_chk
      assign load_use = x_load && any_hit;
    end else begin : g_load_none
      assign load_use = 1'b0;
    end
    if (CHK_BRANCH) begin : g_br_chk
      assign branch_use = id_branch && any_hit;
    end else begin : g_br_none
      assign branch_use = 1'b0;
    end
  endgenerate

  assign stall = load_use || branch_use;

  always_comb begin
    AST_STALL_HAS_CAUSE: assert (!stall || any_hit) else $error("stall w/o hit"); // R8
  end
endmodule

// File: rtl/hzfwd_unit.sv
module hzfwd_unit #(
  parameter int REG_AW        = 5,
  parameter int NTHREADS      = 4,
  parameter bit INTERLEAVED   = 1'b0,
  parameter bit FWD_ALU_EN    = 1'b1,
  parameter bit FWD_MEM_EN    = 1'b1,
  parameter bit FWD_BR_EN     = 1'b1,
  parameter bit INTERLOCK_EN  = 1'b1,
  parameter bit BR_DELAY_SLOT = 1'b0,
  parameter bit LD_DELAY_SLOT = 1'b0,
  localparam int TID_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic [REG_AW-1:0] ex_rs,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [TID_W-1:0]  ex_tid,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_use_rs,
  input  logic              id_use_rt,
  input  logic [TID_W-1:0]  id_tid,
  input  logic              id_branch,
  input  logic              br_taken,
  input  logic              x_we,
  input  logic [REG_AW-1:0] x_rd,
  input  logic [TID_W-1:0]  x_tid,
  input  logic              x_load,
  input  logic              m_we,
  input  logic [REG_AW-1:0] m_rd,
  input  logic [TID_W-1:0]  m_tid,
  input  logic              w_we,
  input  logic [REG_AW-1:0] w_rd,
  input  logic [TID_W-1:0]  w_tid,
  output logic [1:0]        ex_rs_sel,
  output logic [1:0]        ex_rt_sel,
  output logic              br_rs_fwd,
  output logic              br_rt_fwd,
  output logic              stall,
  output logic              squash_slot
);
  // Round-robin interleaving: stages k apart share a thread only if NTHREADS divides k
  localparam bit GAP1_INDEP = INTERLEAVED && (NTHREADS >= 2);
  localparam bit GAP2_INDEP = INTERLEAVED && (NTHREADS >= 3);
  localparam bit USE_ALU    = FWD_ALU_EN && !GAP1_INDEP;
  localparam bit USE_MEM    = FWD_MEM_EN && !GAP2_INDEP;
  localparam bit USE_BR     = FWD_BR_EN  && !GAP2_INDEP;
  localparam bit CHK_LOAD   = INTERLOCK_EN && !LD_DELAY_SLOT && !GAP1_INDEP;
  localparam bit CHK_BRANCH = INTERLOCK_EN && !GAP1_INDEP;

  logic [1:0][REG_AW-1:0] ex_src;
  logic [1:0][REG_AW-1:0] id_src;
  logic [1:0]             id_used;
  logic [1:0]             near_hit, far_hit, xid_hit, mid_hit;
  logic [1:0][1:0]        sel_vec;

  assign ex_src  = {ex_rt, ex_rs};
  assign id_src  = {id_rt, id_rs};
  assign id_used = {id_use_rt, id_use_rs};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_opnd
      hzfwd_match #(.RW(REG_AW), .TW(TID_W)) u_ex_near (
        .src(ex_src[i]), .src_used(1'b1), .src_tid(ex_tid),
        .prod_we(m_we), .prod_rd(m_rd), .prod_tid(m_tid), .hit(near_hit[i]));
      hzfwd_match #(.RW(REG_AW), .TW(TID_W)) u_ex_far (
        .src(ex_src[i]), .src_used(1'b1), .src_tid(ex_tid),
        .prod_we(w_we), .prod_rd(w_rd), .prod_tid(w_tid), .hit(far_hit[i]));
      hzfwd_match #(.RW(REG_AW), .TW(TID_W)) u_id_x (
        .src(id_src[i]), .src_used(id_used[i]), .src_tid(id_tid),
        .prod_we(x_we), .prod_rd(x_rd), .prod_tid(x_tid), .hit(xid_hit[i]));
      hzfwd_match #(.RW(REG_AW), .TW(TID_W)) u_id_m (
        .src(id_src[i]), .src_used(id_used[i]), .src_tid(id_tid),
        .prod_we(m_we), .prod_rd(m_rd), .prod_tid(m_tid), .hit(mid_hit[i]));
      hzfwd_opsel #(.EN_ALU(USE_ALU), .EN_MEM(USE_MEM)) u_sel (
        .near_hit(near_hit[i]), .far_hit(far_hit[i]), .sel(sel_vec[i]));
    end
  endgenerate

  assign ex_rs_sel = sel_vec[0];
  assign ex_rt_sel = sel_vec[1];

  generate
    if (USE_BR) begin : g_br_path
      assign br_rs_fwd = id_branch && mid_hit[0];
      assign br_rt_fwd = id_branch && mid_hit[1];
    end else begin : g_br_pruned
      assign br_rs_fwd = 1'b0;
      assign br_rt_fwd = 1'b0;
    end
  endgenerate

  hzfwd_stall #(.CHK_LOAD(CHK_LOAD), .CHK_BRANCH(CHK_BRANCH)) u_stall (
    .x_load(x_load), .id_branch(id_branch),
    .x_hit_rs(xid_hit[0]), .x_hit_rt(xid_hit[1]), .stall(stall));

  assign squash_slot = !BR_DELAY_SLOT && br_taken;

  always_comb begin
    AST_STALL_NEEDS_WRITER: assert (!stall || (x_we && x_rd != '0)) else $error("stall src"); // R8
    AST_SQUASH_ON_TAKEN: assert (!squash_slot || br_taken) else $error("squash"); // R10
    AST_BRFWD_NEEDS_BRANCH: assert (!(br_rs_fwd || br_rt_fwd) || id_branch) else $error("brfwd"); // R7
    AST_LDSLOT_NO_LOADSTALL: assert (!(LD_DELAY_SLOT && stall && !id_branch)) else $error("ldslot"); // R11
  end
endmodule

// File: tb/hzfwd_unit_tb.sv
`timescale 1ns/1ps
module hzfwd_unit_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] ex_rs, ex_rt, id_rs, id_rt, x_rd, m_rd, w_rd;
  logic [1:0] ex_tid, id_tid, x_tid, m_tid, w_tid;
  logic id_use_rs, id_use_rt, id_branch, br_taken, x_we, x_load, m_we, w_we;
  logic [1:0] d_rs_sel, d_rt_sel, a_rs_sel, a_rt_sel;
  logic d_brs, d_brt, d_stall, d_sq, a_brs, a_brt, a_stall, a_sq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  hzfwd_unit u_dut (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_tid(ex_tid), .id_rs(id_rs), .id_rt(id_rt),
    .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .id_tid(id_tid), .id_branch(id_branch),
    .br_taken(br_taken), .x_we(x_we), .x_rd(x_rd), .x_tid(x_tid), .x_load(x_load),
    .m_we(m_we), .m_rd(m_rd), .m_tid(m_tid), .w_we(w_we), .w_rd(w_rd), .w_tid(w_tid),
    .ex_rs_sel(d_rs_sel), .ex_rt_sel(d_rt_sel), .br_rs_fwd(d_brs), .br_rt_fwd(d_brt),
    .stall(d_stall), .squash_slot(d_sq));

  hzfwd_unit #(.NTHREADS(2), .INTERLEAVED(1'b1), .BR_DELAY_SLOT(1'b1),
               .LD_DELAY_SLOT(1'b1)) u_alt (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_tid(ex_tid[0]), .id_rs(id_rs), .id_rt(id_rt),
    .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .id_tid(id_tid[0]), .id_branch(id_branch),
    .br_taken(br_taken), .x_we(x_we), .x_rd(x_rd), .x_tid(x_tid[0]), .x_load(x_load),
    .m_we(m_we), .m_rd(m_rd), .m_tid(m_tid[0]), .w_we(w_we), .w_rd(w_rd), .w_tid(w_tid[0]),
    .ex_rs_sel(a_rs_sel), .ex_rt_sel(a_rt_sel), .br_rs_fwd(a_brs), .br_rt_fwd(a_brt),
    .stall(a_stall), .squash_slot(a_sq));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    {ex_rs, ex_rt, id_rs, id_rt, x_rd, m_rd, w_rd} = '0;
    {ex_tid, id_tid, x_tid, m_tid, w_tid} = '0;
    {id_use_rs, id_use_rt, id_branch, br_taken, x_we, x_load, m_we, w_we} = '0;
  endtask

  function automatic bit mhit(logic [4:0] s, bit u, logic [1:0] st, bit we,
                              logic [4:0] rd, logic [1:0] pt, bit alt);
    logic [1:0] msk = alt ? 2'b01 : 2'b11;
    return u && we && rd != 0 && rd == s && ((st & msk) == (pt & msk));
  endfunction

  function automatic int exp_sel(logic [4:0] s, bit alt);
    if (!alt && mhit(s, 1, ex_tid, m_we, m_rd, m_tid, alt)) return 1;
    if (mhit(s, 1, ex_tid, w_we, w_rd, w_tid, alt)) return 2;
    return 0;
  endfunction

  task automatic check_model(string tag);
    bit hx, alt;
    for (int k = 0; k < 2; k++) begin
      alt = (k == 1);
      hx = mhit(id_rs, id_use_rs, id_tid, x_we, x_rd, x_tid, alt) ||
           mhit(id_rt, id_use_rt, id_tid, x_we, x_rd, x_tid, alt);
      chk({tag, " R1/R2/R3 rs"}, alt ? a_rs_sel : d_rs_sel, exp_sel(ex_rs, alt));
      chk({tag, " R1/R2/R3 rt"}, alt ? a_rt_sel : d_rt_sel, exp_sel(ex_rt, alt));
      chk({tag, " R7 brs"}, alt ? a_brs : d_brs,
          int'(id_branch && mhit(id_rs, id_use_rs, id_tid, m_we, m_rd, m_tid, alt)));
      chk({tag, " R7 brt"}, alt ? a_brt : d_brt,
          int'(id_branch && mhit(id_rt, id_use_rt, id_tid, m_we, m_rd, m_tid, alt)));
      chk({tag, " R8/R9 stall"}, alt ? a_stall : d_stall,
          int'(!alt && hx && (x_load || id_branch)));
      chk({tag, " R10 squash"}, alt ? a_sq : d_sq, int'(!alt && br_taken));
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  initial begin
    @(negedge clk); clear_all(); settle();
    chk("R6 idle rs", d_rs_sel, 0); chk("R6 idle stall", d_stall, 0);
    @(negedge clk); ex_rs = 3; m_we = 1; m_rd = 3; settle();
    chk("R1 alu path", d_rs_sel, 1); chk("R12 alu pruned", a_rs_sel, 0);
    @(negedge clk); clear_all(); ex_rt = 5; w_we = 1; w_rd = 5; settle();
    chk("R2 mem path", d_rt_sel, 2); chk("R12 mem kept", a_rt_sel, 2);
    @(negedge clk); m_we = 1; m_rd = 5; settle();
    chk("R3 younger wins", d_rt_sel, 1); chk("R12 alt falls to mem", a_rt_sel, 2);
    @(negedge clk); clear_all(); m_we = 1; w_we = 1; x_we = 1; x_load = 1;
    id_use_rs = 1; settle();
    chk("R4 r0 no fwd", d_rs_sel, 0); chk("R4 r0 no stall", d_stall, 0);
    @(negedge clk); clear_all(); ex_rs = 4; ex_tid = 1; m_we = 1; m_rd = 4; m_tid = 0; settle();
    chk("R5 tag mismatch", d_rs_sel, 0);
    @(negedge clk); m_tid = 3; settle();
    chk("R5 dut 2-bit tag", d_rs_sel, 0); chk("R12 alt 1-bit tag ALU pruned", a_rs_sel, 0);
    @(negedge clk); clear_all(); id_branch = 1; id_use_rt = 1; id_rt = 6; m_we = 1; m_rd = 6; settle();
    chk("R7 branch fwd", d_brt, 1); chk("R7 unused rs", d_brs, 0); chk("R12 br kept", a_brt, 1);
    @(negedge clk); clear_all(); id_use_rs = 1; id_rs = 7; x_we = 1; x_rd = 7; x_load = 1;
    ex_rs = 9; m_we = 1; m_rd = 9; w_we = 1; w_rd = 9; settle();
    chk("R8 load-use stall", d_stall, 1); chk("R3 sel during stall", d_rs_sel, 1);
    chk("R11 load slot no stall", a_stall, 0);
    @(negedge clk); x_load = 0; settle();
    chk("R8 non-load no stall", d_stall, 0);
    @(negedge clk); id_branch = 1; settle();
    chk("R9 branch interlock", d_stall, 1); chk("R12 alt no stall", a_stall, 0);
    @(negedge clk); clear_all(); br_taken = 1; settle();
    chk("R10 squash", d_sq, 1); chk("R10 slot keeps", a_sq, 0);
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      ex_rs = 5'($urandom_range(0, 3)); ex_rt = 5'($urandom_range(0, 3));
      id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
      x_rd = 5'($urandom_range(0, 3)); m_rd = 5'($urandom_range(0, 3));
      w_rd = 5'($urandom_range(0, 3));
      ex_tid = 2'($urandom_range(0, 3)); id_tid = 2'($urandom_range(0, 3));
      x_tid = 2'($urandom_range(0, 3)); m_tid = 2'($urandom_range(0, 3));
      w_tid = 2'($urandom_range(0, 3));
      {id_use_rs, id_use_rt, id_branch, br_taken, x_we, x_load, m_we, w_we} = 8'($urandom);
      settle();
      check_model("SWEEP");
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule